// File: doc/BRIEF.md
# Echo Canceller Reset and Mode Sequencer

This block is the control sequencer of a voice echo-cancelling core. It takes the chip reset, the power-down request, a once-per-frame sync strobe and two static mode pins. From these it drives the enable of the serial data outputs, the run enable of the generated bit clock and frame sync, the through-mode select, the coefficient-freeze select and a processing-active flag. It also drives a coefficient-clear sweep, one pulse per coefficient address, which the filter datapath uses to wipe its taps.

After reset is released, the core runs an initialisation window of `BLANK_FRAMES` frames, 800 frames of 8 kHz or 100 ms. During that window input samples are not accepted. Power-down silences the serial outputs and stops the generated clocks. Once power-down has been seen, processing stays off until the next reset, even after the power-down pin is released. Mode pins are sampled only on frame strobes, so mode changes always land on a frame boundary.

Top module: `ec_mode_seq`

## Requirements
- R1: While `rst_ni` is low, `ser_oe_o`, `active_o`, `in_accept_o`, `clr_pulse_o`, `thru_o` and `freeze_o` are 0, and `gen_run_o` is 1 (the generated clocks keep running in reset).
- R2: After reset is released, `in_accept_o` and `active_o` stay 0 until `BLANK_FRAMES` (800) `frame_sync_i` pulses have been sampled. Both rise at the clock edge that samples the last pulse of the window.
- R3: At the first clock edge after reset is released, a clear sweep starts. `clr_pulse_o` is 1 for exactly `NUM_COEF` consecutive cycles, and `clr_addr_o` runs 0, 1, ..., `NUM_COEF`-1.
- R4: `thru_pin_i` and `freeze_pin_i` are sampled only at a clock edge where `frame_sync_i` is 1. A pin change with no strobe leaves `thru_o` and `freeze_o` unchanged.
- R5: While `thru_o` is 1, `active_o` is 0. A sampled change of the through pin from 0 to 1 starts a full clear sweep as in R3, at the same edge where `thru_o` rises.
- R6: `freeze_o` equals the freeze pin value sampled at the last strobe. Leaving through mode does not start a sweep.
- R7: At the third clock edge after `pd_ni` falls, `ser_oe_o`, `gen_run_o`, `active_o` and `in_accept_o` are all 0. While powered down, mode pins and frame strobes are ignored.
- R8: After `pd_ni` returns high, `gen_run_o` returns to 1 at the third edge. `ser_oe_o`, `active_o` and `in_accept_o` stay 0 until a reset is applied.
- R9: `ser_oe_o` goes to 1 at the first clock edge after reset is released, when no power-down is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down request, active low, asynchronous |
| frame_sync_i | input | 1 | One-cycle strobe per 8 kHz frame |
| thru_pin_i | input | 1 | Through-mode pin, 1 selects through mode |
| freeze_pin_i | input | 1 | Coefficient-fix pin, 1 holds coefficients |
| ser_oe_o | output | 1 | Serial data output enable, 0 means high impedance |
| gen_run_o | output | 1 | Run enable for the generated bit clock and frame sync, 0 holds them low |
| thru_o | output | 1 | Through-mode select to the datapath |
| freeze_o | output | 1 | Coefficient update freeze |
| clr_pulse_o | output | 1 | Coefficient clear strobe for the address on clr_addr_o |
| clr_addr_o | output | $clog2(NUM_COEF) | Coefficient address being cleared |
| in_accept_o | output | 1 | Input samples are accepted |
| active_o | output | 1 | Echo processing active |

## Verification
Each result has a fixed latency, and the bench samples it on the falling edge after that latency has elapsed. `ser_oe_o` rises one edge after reset is released. Mode outputs and the through-entry sweep change at the edge that samples the strobe. The blanking end falls on the edge that samples the 800th strobe. Power-down and its release act on the third edge. The bench probes one edge early for power-down, to show that the outputs have not yet moved. Clear pulses go through a scoreboard: expected addresses are queued when a sweep is provoked, and a falling-edge monitor pops one entry per observed pulse. After each sweep the bench checks that the queue is empty, which catches both missing and extra pulses.

// File: rtl/ec_seq_pkg.sv
package ec_seq_pkg;
  typedef struct packed {
    logic thru;
    logic frz;
  } mode_t;
endpackage

// File: rtl/ec_pd_guard.sv
module ec_pd_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  output logic pd_hold_o,
  output logic gen_run_o,
  output logic ser_oe_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic pd_act;
  logic pd_lat_q, gen_q, oe_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[s] <= 1'b1;
        else         sync_q[s] <= pd_ni;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[s] <= 1'b1;
        else         sync_q[s] <= sync_q[s-1];
    end
  end

  assign pd_act = ~sync_q[SYNC_STAGES-1];

  // power-down is remembered until the next reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_lat_q <= 1'b0;
      gen_q    <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      if (pd_act) pd_lat_q <= 1'b1;
      gen_q <= ~pd_act;
      oe_q  <= ~pd_act & ~pd_lat_q;
    end
  end

  assign pd_hold_o = pd_lat_q | pd_act;
  assign gen_run_o = gen_q;
  assign ser_oe_o  = oe_q;
endmodule

// File: rtl/ec_blank_cnt.sv
module ec_blank_cnt #(
  parameter int BLANK_FRAMES = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(BLANK_FRAMES + 1);
  localparam logic [CW-1:0] END_CNT = CW'(BLANK_FRAMES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        cnt_q <= '0;
    else if (tick_i && cnt_q != END_CNT) cnt_q <= cnt_q + CW'(1);

  assign done_o = (cnt_q == END_CNT);
endmodule

// File: rtl/ec_mode_latch.sv
module ec_mode_latch
  import ec_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sample_i,
  input  mode_t pins_i,
  output mode_t mode_o,
  output logic  thru_entry_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       mode_q <= '0;
    else if (sample_i) mode_q <= pins_i;

  assign thru_entry_o = sample_i & pins_i.thru & ~mode_q.thru;
  assign mode_o       = mode_q;
endmodule

// File: rtl/ec_coef_clear.sv
module ec_coef_clear #(
  parameter int NUM_COEF = 64,
  localparam int AW = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  output logic          pulse_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_COEF - 1);

  logic          init_q, busy_q;
  logic [AW-1:0] addr_q;

  // init_q fires one sweep on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      busy_q <= 1'b0;
      addr_q <= '0;
    end else begin
      init_q <= 1'b0;
      if (init_q || trig_i) begin
        busy_q <= 1'b1;
        addr_q <= '0;
      end else if (busy_q) begin
        if (addr_q == LAST) busy_q <= 1'b0;
        else                addr_q <= addr_q + AW'(1);
      end
    end
  end

  assign pulse_o = busy_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/ec_mode_seq.sv
module ec_mode_seq
  import ec_seq_pkg::*;
#(
  parameter int BLANK_FRAMES = 800,
  parameter int NUM_COEF     = 64,
  parameter int SYNC_STAGES  = 2,
  localparam int AW = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_ni,
  input  logic          frame_sync_i,
  input  logic          thru_pin_i,
  input  logic          freeze_pin_i,
  output logic          ser_oe_o,
  output logic          gen_run_o,
  output logic          thru_o,
  output logic          freeze_o,
  output logic          clr_pulse_o,
  output logic [AW-1:0] clr_addr_o,
  output logic          in_accept_o,
  output logic          active_o
);
  logic  pd_hold, blank_done, frame_ok, thru_entry;
  mode_t pins, mode;

  ec_pd_guard #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
    .clk_i, .rst_ni, .pd_ni,
    .pd_hold_o (pd_hold),
    .gen_run_o (gen_run_o),
    .ser_oe_o  (ser_oe_o)
  );

  assign frame_ok = frame_sync_i & ~pd_hold;

  ec_blank_cnt #(.BLANK_FRAMES(BLANK_FRAMES)) u_blank (
    .clk_i, .rst_ni,
    .tick_i (frame_ok),
    .done_o (blank_done)
  );

  assign pins.thru = thru_pin_i;
  assign pins.frz  = freeze_pin_i;

  ec_mode_latch u_mode (
    .clk_i, .rst_ni,
    .sample_i     (frame_ok),
    .pins_i       (pins),
    .mode_o       (mode),
    .thru_entry_o (thru_entry)
  );

  ec_coef_clear #(.NUM_COEF(NUM_COEF)) u_clr (
    .clk_i, .rst_ni,
    .trig_i  (thru_entry),
    .pulse_o (clr_pulse_o),
    .addr_o  (clr_addr_o)
  );

  assign thru_o      = mode.thru;
  assign freeze_o    = mode.frz;
  assign in_accept_o = blank_done & ~pd_hold;
  assign active_o    = in_accept_o & ~mode.thru;
endmodule

// File: rtl/ec_mode_seq_chk.sv
module ec_mode_seq_chk #(
  parameter int NUM_COEF = 64,
  localparam int AW = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_sync_i,
  input logic          ser_oe_o,
  input logic          gen_run_o,
  input logic          thru_o,
  input logic          freeze_o,
  input logic          clr_pulse_o,
  input logic [AW-1:0] clr_addr_o,
  input logic          in_accept_o,
  input logic          active_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_COEF - 1);

  a_r2_active_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> in_accept_o);

  a_r5_thru_blocks_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thru_o |-> !active_o);

  a_r3_clr_addr_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pulse_o && clr_addr_o != LAST) |=>
      (clr_pulse_o && (clr_addr_o == $past(clr_addr_o) + AW'(1) || clr_addr_o == '0)));

  a_r4_mode_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(thru_o) || !$stable(freeze_o)) |-> $past(frame_sync_i));

  a_r7_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_run_o |-> (!ser_oe_o && !active_o && !in_accept_o));

  a_r8_no_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gen_run_o) |-> (!ser_oe_o && !in_accept_o));
endmodule

bind ec_mode_seq ec_mode_seq_chk #(.NUM_COEF(NUM_COEF)) u_chk (
  .clk_i, .rst_ni, .frame_sync_i, .ser_oe_o, .gen_run_o, .thru_o, .freeze_o,
  .clr_pulse_o, .clr_addr_o, .in_accept_o, .active_o
);

// File: tb/ec_mode_seq_tb.sv
module ec_mode_seq_tb;
  localparam int BLANK = 800;
  localparam int NC    = 64;
  localparam int AW    = $clog2(NC);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0, pd_ni = 1'b1, frame_sync_i = 1'b0;
  logic thru_pin_i = 1'b0, freeze_pin_i = 1'b0;
  logic ser_oe_o, gen_run_o, thru_o, freeze_o, clr_pulse_o, in_accept_o, active_o;
  logic [AW-1:0] clr_addr_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #10 clk_i = ~clk_i;

  ec_mode_seq u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_sweep();
    for (int a = 0; a < NC; a++) exp_q.push_back(a);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse();
    frame_sync_i = 1'b1;
    @(negedge clk_i);
    frame_sync_i = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int f = 0; f < n; f++) begin
      pulse();
      idle(7);
    end
  endtask

  // monitor: one expected address per observed clear pulse
  always @(negedge clk_i) begin
    if (rst_ni && clr_pulse_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected clear pulse", int'(clr_addr_o), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(clr_addr_o) == e, "R3 clear address", int'(clr_addr_o), e);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    idle(5);
    chk(ser_oe_o == 0, "R1 ser_oe in reset", ser_oe_o, 0);
    chk(gen_run_o == 1, "R1 gen_run in reset", gen_run_o, 1);
    chk(active_o == 0 && in_accept_o == 0, "R1 active in reset", active_o, 0);
    chk(clr_pulse_o == 0 && thru_o == 0 && freeze_o == 0, "R1 modes in reset", clr_pulse_o, 0);

    push_sweep();
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ser_oe_o == 1, "R9 ser_oe after release", ser_oe_o, 1);
    chk(clr_pulse_o == 1, "R3 sweep starts", clr_pulse_o, 1);

    frames(BLANK - 1);
    chk(in_accept_o == 0, "R2 accept before window end", in_accept_o, 0);
    chk(active_o == 0, "R2 active before window end", active_o, 0);
    chk(exp_q.size() == 0 && clr_pulse_o == 0, "R3 sweep complete", exp_q.size(), 0);
    pulse();
    chk(in_accept_o == 1, "R2 accept at window end", in_accept_o, 1);
    chk(active_o == 1, "R2 active at window end", active_o, 1);
    idle(7);

    thru_pin_i = 1'b1;
    idle(3);
    chk(thru_o == 0, "R4 no sample without strobe", thru_o, 0);
    chk(active_o == 1, "R4 still active", active_o, 1);
    push_sweep();
    pulse();
    chk(thru_o == 1, "R5 through sampled", thru_o, 1);
    chk(active_o == 0, "R5 active off in through", active_o, 0);
    chk(clr_pulse_o == 1, "R5 sweep on entry", clr_pulse_o, 1);
    idle(7);
    frames(9);
    chk(exp_q.size() == 0, "R5 sweep complete", exp_q.size(), 0);

    thru_pin_i = 1'b0;
    freeze_pin_i = 1'b1;
    frames(1);
    chk(freeze_o == 1, "R6 freeze sampled", freeze_o, 1);
    chk(thru_o == 0 && active_o == 1, "R6 through exit", active_o, 1);
    idle(NC + 4);
    chk(exp_q.size() == 0, "R6 no sweep on exit", exp_q.size(), 0);
    freeze_pin_i = 1'b0;
    frames(1);
    chk(freeze_o == 0, "R6 freeze released", freeze_o, 0);

    pd_ni = 1'b0;
    idle(2);
    chk(gen_run_o == 1 && ser_oe_o == 1, "R7 not yet down", gen_run_o, 1);
    idle(1);
    chk(gen_run_o == 0, "R7 gen_run down", gen_run_o, 0);
    chk(ser_oe_o == 0, "R7 ser_oe down", ser_oe_o, 0);
    chk(active_o == 0 && in_accept_o == 0, "R7 active down", active_o, 0);
    thru_pin_i = 1'b1;
    freeze_pin_i = 1'b1;
    frames(2);
    chk(thru_o == 0 && freeze_o == 0, "R7 pins ignored", thru_o, 0);
    thru_pin_i = 1'b0;
    freeze_pin_i = 1'b0;

    pd_ni = 1'b1;
    idle(3);
    chk(gen_run_o == 1, "R8 gen_run back", gen_run_o, 1);
    chk(ser_oe_o == 0, "R8 ser_oe held off", ser_oe_o, 0);
    frames(3);
    chk(active_o == 0 && in_accept_o == 0, "R8 no resume", active_o, 0);

    rst_ni = 1'b0;
    #1;
    chk(ser_oe_o == 0 && gen_run_o == 1, "R1 async reset", ser_oe_o, 0);
    idle(3);
    push_sweep();
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ser_oe_o == 1, "R9 ser_oe after second reset", ser_oe_o, 1);
    frames(10);
    chk(in_accept_o == 0, "R2 window restarts", in_accept_o, 0);
    chk(exp_q.size() == 0, "R3 second sweep complete", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end
endmodule